// File: doc/BRIEF.md
# Two-Pin Multi-Purpose I/O Controller

This block manages two general-purpose pads through one 32-bit configuration word that is written over a simple register bus. Each pad takes a 2-bit mode. The mode makes the pad a plain input, an inverted input, or an output that holds a constant level. For each pad the block drives an output-enable and an output level. It also returns a conditioned pad value, which is synchronized and polarity-corrected when the pad is an input and equals the driven level when the pad is an output.

Two per-pad enables route each pad into the power logic. A wake-event enable lets a rising edge of the conditioned input set a sticky event status flag. A separate clear input resets that flag. A power-down enable forwards the conditioned value as that pad's contribution to an external power-down request filter.

Each pad is tracked by a small state machine with three states. PIN_DRIVE covers output mode. PIN_LOW and PIN_HIGH hold the last conditioned input level. The named transitions are: any state to PIN_DRIVE when an output mode is selected. PIN_DRIVE to PIN_LOW or PIN_HIGH when an input mode returns, following the current conditioned level and raising no event. PIN_LOW to PIN_HIGH, the "rise" transition, which is the only one that reports an edge. PIN_HIGH to PIN_LOW on a falling level. The event flag has its own machine with two states, EV_IDLE and EV_PENDING. The "arm" transition goes from EV_IDLE to EV_PENDING when an enabled rise occurs. The "release" transition goes from EV_PENDING to EV_IDLE on a clear with no simultaneous enabled rise.

Top module: `mio_ctrl`

## Requirements
- R1: After reset, rd_data is 0, pad_oe and pad_out are 0, evt_status is 0 and pdn_req is 0, so both pads are non-inverting inputs.
- R2: A cycle with cfg_wr high stores cfg_wdata[7:0] at that clock edge. The next cycle rd_data returns those eight bits in [7:0], and rd_data[31:8] is always 0 whatever is written there.
- R3: Mode 00 (pad 0 in bits [1:0], pad 1 in bits [3:2]) makes the pad an input with pad_oe low. pin_val follows pad_in after two clock edges of synchronization, and not after only one.
- R4: Mode 01 makes the pad an inverted input: pin_val is the complement of the synchronized pad_in.
- R5: Mode 10 drives 0 and mode 11 drives 1. pad_oe is high and pad_out equals the low mode bit from the cycle after the write. pin_val equals the driven level, and pad_in has no effect.
- R6: When the wake enable of a pad (bit 4 for pad 0, bit 5 for pad 1) is 1 and the pad is in an input mode, a rising edge of its conditioned value sets evt_status on the third clock edge after pad_in changes. This also holds for a falling pad_in in inverted mode.
- R7: A pad whose wake enable is 0, or a pad in an output mode, never sets evt_status.
- R8: evt_status stays set until evt_clr is sampled high. The flag is then 0 from the next cycle. An enabled rise in the same cycle as the clear wins, and the flag stays 1.
- R9: pdn_req[i] equals the pad's power-down enable (bit 6 for pad 0, bit 7 for pad 1) ANDed with pin_val[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| rd_data | output | 32 | Configuration readback, reserved bits zero |
| pad_in | input | 2 | Raw pad input levels |
| pad_oe | output | 2 | Pad output enables |
| pad_out | output | 2 | Pad output levels |
| pin_val | output | 2 | Conditioned pad values |
| evt_clr | input | 1 | Clears the wake-event status |
| evt_status | output | 1 | Sticky wake-event status |
| pdn_req | output | 2 | Per-pad power-down request contribution |

## Verification
A pad state machine left in the wrong state shows up at evt_status. A stale PIN_HIGH swallows the next rise, so the flag stays low on the third edge where it should rise. A PIN_DRIVE exit that counts as a rise sets the flag one cycle after a mode write. An event machine stuck in EV_PENDING, or released too early, appears as the wrong flag value in the cycle right after a clear. A wrong stored configuration bit appears on pad_oe, pad_out or rd_data in the first cycle after the write.

// File: rtl/mio_pkg.sv
package mio_pkg;

    typedef enum logic [1:0] {
        MODE_IN   = 2'b00,
        MODE_INV  = 2'b01,
        MODE_DRV0 = 2'b10,
        MODE_DRV1 = 2'b11
    } mio_mode_e;

    typedef enum logic [1:0] {
        PIN_LOW   = 2'b00,
        PIN_HIGH  = 2'b01,
        PIN_DRIVE = 2'b10
    } pin_state_e;

    typedef enum logic {
        EV_IDLE    = 1'b0,
        EV_PENDING = 1'b1
    } evt_state_e;

endpackage

// File: rtl/mio_cfg_reg.sv
module mio_cfg_reg #(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] rd_data
);

    // Only the implemented field bits are stored; the rest are dropped.
    logic unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

    assign rd_data = DATA_W'(cfg_q);

endmodule

// File: rtl/mio_pin.sv
module mio_pin
    import mio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  mio_mode_e mode,
    input  logic      pad_in,
    output logic      pad_oe,
    output logic      pad_out,
    output logic      pin_val,
    output logic      rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    pin_state_e             state_q, state_d;
    logic                   out_mode;
    logic                   drive_lvl;
    logic                   cond;

    // Input synchronizer chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
        end
    end

    always_comb begin
        out_mode  = 1'b0;
        drive_lvl = 1'b0;
        cond      = sync_q[SYNC_STAGES-1];
        unique case (mode)
            MODE_IN:   cond = sync_q[SYNC_STAGES-1];
            MODE_INV:  cond = ~sync_q[SYNC_STAGES-1];
            MODE_DRV0: begin out_mode = 1'b1; drive_lvl = 1'b0; end
            MODE_DRV1: begin out_mode = 1'b1; drive_lvl = 1'b1; end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        if (out_mode) begin
            state_d = PIN_DRIVE;
        end else begin
            unique case (state_q)
                PIN_DRIVE: state_d = cond ? PIN_HIGH : PIN_LOW;
                PIN_LOW: begin
                    if (cond) begin
                        state_d = PIN_HIGH;
                        rise    = 1'b1;
                    end
                end
                PIN_HIGH: begin
                    if (!cond) state_d = PIN_LOW;
                end
                default: state_d = PIN_LOW;
            endcase
        end
    end

    assign pad_oe  = out_mode;
    assign pad_out = out_mode & drive_lvl;
    assign pin_val = out_mode ? drive_lvl : cond;

endmodule

// File: rtl/mio_evt.sv
module mio_evt
    import mio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr,
    output logic status
);

    evt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (set_req) state_d = EV_PENDING;
            EV_PENDING: if (clr && !set_req) state_d = EV_IDLE;
            default:    state_d = EV_IDLE;
        endcase
    end

    assign status = (state_q == EV_PENDING);

endmodule

// File: rtl/mio_ctrl.sv
module mio_ctrl
    import mio_pkg::*;
#(
    parameter int NPINS       = 2,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pin_val,
    input  logic              evt_clr,
    output logic              evt_status,
    output logic [NPINS-1:0]  pdn_req
);

    localparam int MODE_LSB = 0;
    localparam int WAKE_LSB = 2 * NPINS;
    localparam int PDN_LSB  = 3 * NPINS;
    localparam int CFG_W    = 4 * NPINS;

    logic [CFG_W-1:0] cfg_q;
    logic [NPINS-1:0] wake_en;
    logic [NPINS-1:0] pdn_en;
    logic [NPINS-1:0] rise_vec;

    mio_cfg_reg #(
        .DATA_W (DATA_W),
        .CFG_W  (CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    assign wake_en = cfg_q[WAKE_LSB +: NPINS];
    assign pdn_en  = cfg_q[PDN_LSB +: NPINS];

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        mio_pin #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mio_mode_e'(cfg_q[MODE_LSB + 2*g +: 2])),
            .pad_in  (pad_in[g]),
            .pad_oe  (pad_oe[g]),
            .pad_out (pad_out[g]),
            .pin_val (pin_val[g]),
            .rise    (rise_vec[g])
        );
    end

    assign pdn_req = pdn_en & pin_val;

    mio_evt u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(|(rise_vec & wake_en)),
        .clr    (evt_clr),
        .status (evt_status)
    );

endmodule

// File: rtl/mio_ctrl_chk.sv
module mio_ctrl_chk #(
    parameter int NPINS  = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic              evt_clr,
    input logic              evt_status,
    input logic [NPINS-1:0]  pdn_req,
    input logic [NPINS-1:0]  rise_vec,
    input logic [NPINS-1:0]  wake_en,
    input logic [NPINS-1:0]  pdn_en
);

    localparam int CFG_W = 4 * NPINS;

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:CFG_W] == '0);

    a_r5_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[1]) |=> (pad_oe[0] && (pad_out[0] == $past(cfg_wdata[0]))));

    a_r3_input_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_wdata[1]) |=> !pad_oe[0]);

    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_vec & wake_en)) |=> evt_status);

    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_status) |-> $past(|(rise_vec & wake_en)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_status && !evt_clr) |=> evt_status);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !(|(rise_vec & wake_en))) |=> !evt_status);

    a_r9_pdn_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_req & ~pdn_en) == '0);

endmodule

bind mio_ctrl mio_ctrl_chk #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .rd_data    (rd_data),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .evt_clr    (evt_clr),
    .evt_status (evt_status),
    .pdn_req    (pdn_req),
    .rise_vec   (rise_vec),
    .wake_en    (wake_en),
    .pdn_en     (pdn_en)
);

// File: tb/tb_mio_ctrl.sv
`timescale 1ns/1ps
module tb_mio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  pad_in = '0;
    logic [1:0]  pad_oe;
    logic [1:0]  pad_out;
    logic [1:0]  pin_val;
    logic        evt_clr = 1'b0;
    logic        evt_status;
    logic [1:0]  pdn_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mio_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .rd_data    (rd_data),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pin_val    (pin_val),
        .evt_clr    (evt_clr),
        .evt_status (evt_status),
        .pdn_req    (pdn_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic clear_evt();
        @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic settle(input logic [31:0] d);
        write_cfg(32'h0);
        pad_in = 2'b00;
        step(4);
        write_cfg(d);
        step(1);
        clear_evt();
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 pad_oe", {30'b0, pad_oe}, 32'h0);
        check("R1 pad_out", {30'b0, pad_out}, 32'h0);
        check("R1 evt", {31'b0, evt_status}, 32'h0);
        check("R1 pdn", {30'b0, pdn_req}, 32'h0);
    endtask

    task automatic t_regs();
        write_cfg(32'hFFFF_FFA5);
        check("R2 readback", rd_data, 32'h0000_00A5);
        write_cfg(32'h1234_5600);
        check("R2 reserved", rd_data, 32'h0);
    endtask

    task automatic t_input();
        settle(32'h0);
        @(negedge clk);
        pad_in = 2'b01;
        step(1);
        check("R3 one edge not yet", {30'b0, pin_val}, 32'h0);
        step(1);
        check("R3 follow", {30'b0, pin_val}, 32'h1);
        check("R3 oe low", {30'b0, pad_oe}, 32'h0);
    endtask

    task automatic t_invert();
        settle(32'h05);
        @(negedge clk);
        pad_in = 2'b01;
        step(2);
        check("R4 inverted", {30'b0, pin_val}, 32'h2);
    endtask

    task automatic t_output();
        settle(32'h0E);
        check("R5 oe", {30'b0, pad_oe}, 32'h3);
        check("R5 out", {30'b0, pad_out}, 32'h2);
        pad_in = 2'b01;
        step(3);
        check("R5 pin_val drive", {30'b0, pin_val}, 32'h2);
    endtask

    task automatic t_event();
        settle(32'h10);
        check("R8 clear", {31'b0, evt_status}, 32'h0);
        @(negedge clk);
        pad_in = 2'b01;
        step(2);
        check("R6 not before third edge", {31'b0, evt_status}, 32'h0);
        step(1);
        check("R6 set", {31'b0, evt_status}, 32'h1);
        pad_in = 2'b00;
        step(5);
        check("R8 sticky", {31'b0, evt_status}, 32'h1);
        clear_evt();
        check("R8 cleared", {31'b0, evt_status}, 32'h0);
        // inverted input: falling pad raises conditioned value
        settle(32'h11);
        pad_in = 2'b01;
        step(4);
        clear_evt();
        @(negedge clk);
        pad_in = 2'b00;
        step(3);
        check("R6 inverted fall", {31'b0, evt_status}, 32'h1);
    endtask

    task automatic t_disabled();
        settle(32'h10);
        @(negedge clk);
        pad_in = 2'b10;
        step(4);
        check("R7 disabled pad", {31'b0, evt_status}, 32'h0);
        settle(32'h12);
        pad_in = 2'b01;
        step(4);
        write_cfg(32'h13);
        step(3);
        check("R7 output mode", {31'b0, evt_status}, 32'h0);
        write_cfg(32'h10);
        step(3);
        check("R7 leaving output", {31'b0, evt_status}, 32'h0);
    endtask

    task automatic t_setclr();
        settle(32'h10);
        @(negedge clk);
        pad_in = 2'b01;
        step(2);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        check("R8 set wins", {31'b0, evt_status}, 32'h1);
    endtask

    task automatic t_pdn();
        settle(32'h40);
        @(negedge clk);
        pad_in = 2'b11;
        step(2);
        check("R9 pdn pad0 only", {30'b0, pdn_req}, 32'h1);
        write_cfg(32'hC0);
        check("R9 pdn both", {30'b0, pdn_req}, 32'h3);
        pad_in = 2'b00;
        step(2);
        check("R9 pdn low", {30'b0, pdn_req}, 32'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_input();
        t_invert();
        t_output();
        t_event();
        t_disabled();
        t_setclr();
        t_pdn();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule